// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through its clock-control power states. From normal execution the core can drop into a halt state when a halt instruction retires. A stop-clock request parks the core in Stop-Grant. Inside Stop-Grant a sleep request stops every internal clock while context and the PLL are kept. Deep Sleep also shuts the PLL off. Deeper Sleep adds a request to the voltage regulator for a lower core voltage.

The block drives a core clock enable, a PLL enable, a flag that says bus snoops may be serviced, a one-cycle snoop-service pulse, the low-voltage request and the current state code. When the core leaves Deep Sleep, the PLL is switched back on and the block waits a programmable number of cycles for lock before it returns to Sleep. A sleep request raised where sleep is not allowed is ignored and recorded in a sticky error flag. The stop-clock, sleep, deep and deeper requests are active low.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state code is 0 (normal), core_clk_en and pll_en are 1, and lowv_req, snoop_svc and proto_err are 0.
- R2: State codes are 0 normal, 1 halt, 2 stop-grant, 3 sleep, 4 deep sleep, 5 deeper sleep, 6 relock. core_clk_en is 1 only in code 0, pll_en is 0 only in codes 4 and 5, snoop_ok is 1 only in codes 1 and 2, and lowv_req is 1 only in code 5.
- R3: In normal, stopclk_n low moves the block to stop-grant, and this takes priority over a halt_pulse. Otherwise a halt_pulse moves it to halt.
- R4: In halt, stopclk_n low moves the block to stop-grant, and otherwise irq moves it to normal. When stop-grant ends because stopclk_n goes high, the block returns to halt if it entered from halt, and to normal otherwise.
- R5: snoop_svc is 1 for exactly the cycle after each cycle in which snoop_req and snoop_ok are both 1.
- R6: Sleep is entered only from stop-grant, when sleep_n is low. In sleep, sleep_n high returns the block to stop-grant unless deep_n is low.
- R7: In sleep, deep_n low moves the block to deep sleep. In deep sleep, deeper_n low moves it to deeper sleep. In deeper sleep, deeper_n high returns it to deep sleep.
- R8: In deep sleep, with deep_n and deeper_n both high, the block enters relock, stays there for lock_cycles+1 cycles (the value sampled on entry) and then moves to sleep.
- R9: sleep_n low while in normal or halt sets proto_err, which stays 1 until reset. In that cycle the state does not change, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_pulse | input | 1 | Halt instruction executed |
| stopclk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| deep_n | input | 1 | Deep-sleep request, active low |
| deeper_n | input | 1 | Deeper-sleep request, active low |
| snoop_req | input | 1 | Bus snoop pending |
| irq | input | 1 | Interrupt pending |
| lock_cycles | input | LOCK_W | PLL lock wait, in cycles minus one |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_ok | output | 1 | Snoops may be serviced |
| snoop_svc | output | 1 | Snoop-service pulse |
| lowv_req | output | 1 | Lower core voltage request |
| proto_err | output | 1 | Sticky illegal-sleep flag |
| state_code | output | 3 | Current state |

## Verification
In halt, a snoop can be serviced in the same cycle that an interrupt or a stop-clock request moves the block out of halt. The bench raises snoop_req together with irq while in halt. It then expects the state to become normal and a snoop_svc pulse to appear in the same following cycle. A second collision puts an illegal sleep request in the same cycle as a halt pulse. There the error must be recorded and the halt transition suppressed. Random cycles in which snoops, interrupts and the request lines overlap are compared against a cycle model kept in the bench.

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_pulse,
  input  logic              stopclk_n,
  input  logic              sleep_n,
  input  logic              deep_n,
  input  logic              deeper_n,
  input  logic              snoop_req,
  input  logic              irq,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic              core_clk_en,
  output logic              pll_en,
  output logic              snoop_ok,
  output logic              snoop_svc,
  output logic              lowv_req,
  output logic              proto_err,
  output logic [2:0]        state_code
);
  localparam logic [2:0] S_RUN  = 3'd0;
  localparam logic [2:0] S_HALT = 3'd1;
  localparam logic [2:0] S_SGNT = 3'd2;
  localparam logic [2:0] S_SLP  = 3'd3;
  localparam logic [2:0] S_DSLP = 3'd4;
  localparam logic [2:0] S_DPR  = 3'd5;
  localparam logic [2:0] S_LOCK = 3'd6;

  logic [2:0]        st, nx;
  logic              from_halt, from_halt_nx;
  logic [LOCK_W-1:0] cnt;
  logic              bad_sleep;

  assign bad_sleep = !sleep_n && (st == S_RUN || st == S_HALT);

  always_comb begin
    nx = st;
    from_halt_nx = from_halt;
    case (st)
      S_RUN: begin
        if (bad_sleep) nx = st;
        else if (!stopclk_n) begin nx = S_SGNT; from_halt_nx = 1'b0; end
        else if (halt_pulse) nx = S_HALT;
      end
      S_HALT: begin
        if (bad_sleep) nx = st;
        else if (!stopclk_n) begin nx = S_SGNT; from_halt_nx = 1'b1; end
        else if (irq) nx = S_RUN;
      end
      S_SGNT: begin
        if (!sleep_n) nx = S_SLP;
        else if (stopclk_n) nx = from_halt ? S_HALT : S_RUN;
      end
      S_SLP: begin
        if (!deep_n) nx = S_DSLP;
        else if (sleep_n) nx = S_SGNT;
      end
      S_DSLP: begin
        if (!deeper_n) nx = S_DPR;
        else if (deep_n) nx = S_LOCK;
      end
      S_DPR:  if (deeper_n) nx = S_DSLP;
      S_LOCK: if (cnt == '0) nx = S_SLP;
      default: nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      from_halt <= 1'b0;
      cnt       <= '0;
      snoop_svc <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st        <= nx;
      from_halt <= from_halt_nx;
      if (st == S_DSLP && nx == S_LOCK) cnt <= lock_cycles;
      else if (st == S_LOCK && cnt != '0) cnt <= cnt - 1'b1;
      snoop_svc <= snoop_ok && snoop_req;
      proto_err <= proto_err | bad_sleep;
    end
  end

  assign state_code  = st;
  assign core_clk_en = (st == S_RUN);
  assign pll_en      = !(st == S_DSLP || st == S_DPR);
  assign snoop_ok    = (st == S_HALT || st == S_SGNT);
  assign lowv_req    = (st == S_DPR);

  a_r6_sleep_only_via_sgnt: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN || st == S_HALT) |=> st != S_SLP);
  a_r2_lowv_implies_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
    lowv_req |-> !pll_en);
  a_r2_core_clk_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> pll_en);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r9_bad_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sleep |=> ($stable(state_code) && proto_err));
  a_r5_snoop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_ok && snoop_req) |=> snoop_svc);
  a_r8_relock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DSLP && deep_n && deeper_n) |=> (st == S_LOCK && pll_en));
  a_r7_deeper_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DPR && deeper_n) |=> st == S_DSLP);
endmodule

// File: tb/pwr_state_ctrl_bench.sv
module pwr_state_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_pulse = 0, stopclk_n = 1, sleep_n = 1, deep_n = 1, deeper_n = 1;
  logic snoop_req = 0, irq = 0;
  logic [7:0] lock_cycles = 8'd0;
  logic core_clk_en, pll_en, snoop_ok, snoop_svc, lowv_req, proto_err;
  logic [2:0] state_code;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_st = 0, m_cnt = 0;
  bit m_fh = 0, m_err = 0, m_svc = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl #(.LOCK_W(8)) u_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_pulse(halt_pulse), .stopclk_n(stopclk_n),
    .sleep_n(sleep_n), .deep_n(deep_n), .deeper_n(deeper_n), .snoop_req(snoop_req),
    .irq(irq), .lock_cycles(lock_cycles), .core_clk_en(core_clk_en), .pll_en(pll_en),
    .snoop_ok(snoop_ok), .snoop_svc(snoop_svc), .lowv_req(lowv_req),
    .proto_err(proto_err), .state_code(state_code));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit e_clk(int s);  return s == 0; endfunction
  function automatic bit e_pll(int s);  return !(s == 4 || s == 5); endfunction
  function automatic bit e_snp(int s);  return s == 1 || s == 2; endfunction
  function automatic bit e_lowv(int s); return s == 5; endfunction

  task automatic compare_all();
    chk(state_code == m_st, "state R3 R4 R6 R7 R8", state_code, m_st);
    chk(core_clk_en == e_clk(m_st), "R2 core_clk_en", core_clk_en, e_clk(m_st));
    chk(pll_en == e_pll(m_st), "R2 pll_en", pll_en, e_pll(m_st));
    chk(snoop_ok == e_snp(m_st), "R2 snoop_ok", snoop_ok, e_snp(m_st));
    chk(lowv_req == e_lowv(m_st), "R2 lowv_req", lowv_req, e_lowv(m_st));
    chk(snoop_svc == m_svc, "R5 snoop_svc", snoop_svc, m_svc);
    chk(proto_err == m_err, "R9 proto_err", proto_err, m_err);
  endtask

  task automatic model_step();
    int nx = m_st; bit fh = m_fh; int cnt = m_cnt;
    bit bad = !sleep_n && (m_st == 0 || m_st == 1);
    case (m_st)
      0: if (!bad) begin if (!stopclk_n) begin nx = 2; fh = 0; end else if (halt_pulse) nx = 1; end
      1: if (!bad) begin if (!stopclk_n) begin nx = 2; fh = 1; end else if (irq) nx = 0; end
      2: if (!sleep_n) nx = 3; else if (stopclk_n) nx = m_fh ? 1 : 0;
      3: if (!deep_n) nx = 4; else if (sleep_n) nx = 2;
      4: if (!deeper_n) nx = 5; else if (deep_n) begin nx = 6; cnt = lock_cycles; end
      5: if (deeper_n) nx = 4;
      6: if (m_cnt == 0) nx = 3; else cnt = m_cnt - 1;
      default: nx = 0;
    endcase
    m_svc = e_snp(m_st) && snoop_req;
    m_err = m_err | bad;
    m_st = nx; m_fh = fh; m_cnt = cnt;
  endtask

  task automatic step(input bit h, input bit sc, input bit sl, input bit dp,
                      input bit dr, input bit sn, input bit iq);
    halt_pulse = h; stopclk_n = sc; sleep_n = sl; deep_n = dp; deeper_n = dr;
    snoop_req = sn; irq = iq;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(state_code == 0, "R1 state", state_code, 0);
    chk(core_clk_en && pll_en, "R1 clocks", {core_clk_en, pll_en}, 3);
    chk(!lowv_req && !snoop_svc && !proto_err, "R1 flags", {lowv_req, snoop_svc, proto_err}, 0);

    step(1,1,1,1,1,0,0); chk(state_code == 1, "R3 halt entry", state_code, 1);
    step(0,0,1,1,1,0,0); chk(state_code == 2, "R4 halt to stop-grant", state_code, 2);
    step(0,1,1,1,1,0,0); chk(state_code == 1, "R4 return to halt", state_code, 1);
    step(0,1,1,1,1,1,1);
    chk(state_code == 0 && snoop_svc, "R5 snoop with irq exit", {state_code, snoop_svc}, 1);
    step(0,1,1,1,1,0,0); chk(!snoop_svc, "R5 pulse ends", snoop_svc, 0);
    step(1,0,1,1,1,0,0); chk(state_code == 2, "R3 stop-clock beats halt", state_code, 2);
    step(0,0,0,1,1,0,0); chk(state_code == 3, "R6 sleep entry", state_code, 3);
    step(0,0,0,0,1,0,0); chk(state_code == 4 && !pll_en, "R7 deep entry", state_code, 4);
    step(0,0,0,0,0,0,0); chk(state_code == 5 && lowv_req, "R7 deeper entry", state_code, 5);
    step(0,0,0,0,1,0,0); chk(state_code == 4 && !lowv_req, "R7 deeper exit", state_code, 4);
    lock_cycles = 8'd3;
    step(0,0,0,1,1,0,0); chk(state_code == 6 && pll_en, "R8 relock entry", state_code, 6);
    for (int i = 0; i < 3; i++) begin
      step(0,0,0,1,1,0,0); chk(state_code == 6, "R8 relock wait", state_code, 6);
    end
    step(0,0,0,1,1,0,0); chk(state_code == 3, "R8 relock done", state_code, 3);
    step(0,0,1,1,1,0,0); chk(state_code == 2, "R6 sleep exit", state_code, 2);
    step(0,1,1,1,1,0,0); chk(state_code == 0, "R4 return to normal", state_code, 0);
    step(1,1,0,1,1,0,0);
    chk(state_code == 0 && proto_err, "R9 illegal sleep", {state_code, proto_err}, 1);
    step(0,1,1,1,1,0,0); chk(proto_err, "R9 sticky", proto_err, 1);

    for (int c = 0; c < 4000; c++) begin
      bit sc = stopclk_n, sl = sleep_n, dp = deep_n, dr = deeper_n;
      if ($urandom % 6 == 0) sc = !sc;
      if ($urandom % 5 == 0) sl = !sl;
      if ($urandom % 5 == 0) dp = !dp;
      if ($urandom % 4 == 0) dr = !dr;
      if ((m_st == 0 || m_st == 1) && ($urandom % 40 != 0)) sl = 1;
      if ($urandom % 16 == 0) lock_cycles = 8'($urandom % 7);
      step($urandom % 8 == 0, sc, sl, dp, dr, $urandom % 4 == 0, $urandom % 6 == 0);
    end
    finish_run();
  end
endmodule